// File: doc/BRIEF.md
# Double-Buffered Auxiliary PWM Generator

This block produces one pulse-width-modulated output from a free-running up-counter. Software programs it through a small 32-bit register port. Two registers hold the period and the compare value that the counter uses now. A second pair holds staged copies. A staged write is held back and moves into the working pair only when the current period ends, so a running waveform can be retuned without a truncated or stretched pulse.

A 16-bit control word sets up the generator:

- Bit 4 starts and stops the counter.
- Bit 9 turns the PWM output on. While it is clear the output stays low.
- Bit 10 inverts the waveform, so the compare value sets the low time instead of the high time.
- Bits 7:6 are a sync-disable field. It is stored and reads back, but no sync logic sits behind it.

A period value P gives P counter cycles per waveform period. The counter steps through 0 .. P-1, and the output is high while the count is below the compare value. Writing the working registers directly changes the waveform on the next cycle. This is how the block is set up before it starts running.

Top module: `aux_pwm_shadowed`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is 0.
- R2: Byte addresses are decoded as follows: working period at 0x08, working compare at 0x0C, staged period at 0x10, staged compare at 0x14, control at 0x2A. The control register stores data bits 15:0 and reads back with bits 31:16 as 0. A read on cycle n returns its data on `bus_rdata` in cycle n+1. Any other address, and any cycle without a read, returns 0.
- R3: While control bit 4 is 1 the counter advances every cycle. While it is 0 the counter holds its value, so the output holds too.
- R4: With working period P ≥ 1 the counter steps 0, 1, ..., P-1 and then returns to 0. This end-of-period step is the wrap. A period of 0 behaves as a period of 1.
- R5: With control bit 10 = 0 and bit 9 = 1, `pwm_out` is 1 exactly when the count is below the working compare value C. C = 0 gives a constant 0, and C ≥ P gives a constant 1, which includes P = 1 with C = 1.
- R6: With control bit 10 = 1 and bit 9 = 1, `pwm_out` is the complement of the R5 value.
- R7: With control bit 9 = 0, `pwm_out` is 0 whatever the counter, compare and bit 10 hold.
- R8: A write to a staged register sets a pending flag. On the next wrap the working period and compare take both staged values, and the period in progress completes with the old values.
- R9: A wrap with no pending flag copies nothing. The transfer clears the flag, unless a staged write lands in the same cycle as the wrap. In that case the flag stays set, and the copy carries the staged values held before that write.
- R10: A direct write to a working register is used from the next cycle. If it coincides with a transfer, the direct write wins for that register.
- R11: Control bits 7:6 read back as written and have no effect on `pwm_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read (qualified by bus_valid) |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions assume the bus inputs hold known 0/1 values once reset is released. They also assume only one register is addressed per cycle. A direct working-register write and a staged transfer may legally fall in the same cycle, so the stability properties exempt cycles that carry a direct write. The stimulus drives every bus input at mid-cycle and drops `bus_valid` after each access. It also issues back-to-back staged writes on a short period, so that some of them land on a wrap cycle and the pending-flag corner of R9 is covered.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int unsigned CTRL_W = 16;

  // register byte offsets
  localparam logic [7:0] OFF_PER_ACT = 8'h08;
  localparam logic [7:0] OFF_CMP_ACT = 8'h0C;
  localparam logic [7:0] OFF_PER_SHD = 8'h10;
  localparam logic [7:0] OFF_CMP_SHD = 8'h14;
  localparam logic [7:0] OFF_CTRL    = 8'h2A;

  // control word bit positions
  localparam int unsigned BIT_RUN  = 4;
  localparam int unsigned BIT_MODE = 9;
  localparam int unsigned BIT_INV  = 10;

  typedef struct packed {
    logic run;
    logic mode;
    logic inv;
  } apwm_mode_t;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wrap,
  output logic [DATA_W-1:0] per_act,
  output logic [DATA_W-1:0] cmp_act,
  output apwm_mode_t        mode_bits,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] per_act_q, per_act_d, cmp_act_q, cmp_act_d;
  logic [DATA_W-1:0] per_shd_q, cmp_shd_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              pend_q, pend_d;
  logic              hit_pa, hit_ca, hit_ps, hit_cs, hit_ctl, rd_en, xfer;
  logic              per_act_en, cmp_act_en;

  // decode and next state
  always_comb begin
    hit_pa  = bus_valid & bus_write & (bus_addr == ADDR_W'(OFF_PER_ACT));
    hit_ca  = bus_valid & bus_write & (bus_addr == ADDR_W'(OFF_CMP_ACT));
    hit_ps  = bus_valid & bus_write & (bus_addr == ADDR_W'(OFF_PER_SHD));
    hit_cs  = bus_valid & bus_write & (bus_addr == ADDR_W'(OFF_CMP_SHD));
    hit_ctl = bus_valid & bus_write & (bus_addr == ADDR_W'(OFF_CTRL));
    rd_en   = bus_valid & ~bus_write;
    xfer    = wrap & pend_q;

    per_act_en = hit_pa | xfer;
    per_act_d  = hit_pa ? bus_wdata : per_shd_q;
    cmp_act_en = hit_ca | xfer;
    cmp_act_d  = hit_ca ? bus_wdata : cmp_shd_q;

    pend_d = hit_ps | hit_cs | (pend_q & ~wrap);

    rdata_d = '0;
    if (rd_en) begin
      unique case (bus_addr)
        ADDR_W'(OFF_PER_ACT): rdata_d = per_act_q;
        ADDR_W'(OFF_CMP_ACT): rdata_d = cmp_act_q;
        ADDR_W'(OFF_PER_SHD): rdata_d = per_shd_q;
        ADDR_W'(OFF_CMP_SHD): rdata_d = cmp_shd_q;
        ADDR_W'(OFF_CTRL):    rdata_d = DATA_W'(ctrl_q);
        default:              rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_act_q <= '0;
    end else if (per_act_en) begin
      per_act_q <= per_act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act_q <= '0;
    end else if (cmp_act_en) begin
      cmp_act_q <= cmp_act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_shd_q <= '0;
    end else if (hit_ps) begin
      per_shd_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_shd_q <= '0;
    end else if (hit_cs) begin
      cmp_shd_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit_ctl) begin
      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      pend_q  <= pend_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb begin
    per_act        = per_act_q;
    cmp_act        = cmp_act_q;
    mode_bits.run  = ctrl_q[BIT_RUN];
    mode_bits.mode = ctrl_q[BIT_MODE];
    mode_bits.inv  = ctrl_q[BIT_INV];
    bus_rdata      = rdata_q;
  end

  // R8: working pair holds between wraps unless written directly
  a_r8_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !hit_pa && !hit_ca) |=> ($stable(per_act_q) && $stable(cmp_act_q)));

  // R9: a wrap without a pending staged write copies nothing
  a_r9_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !hit_pa && !hit_ca) |=> ($stable(per_act_q) && $stable(cmp_act_q)));

  // R9: transfer clears the pending flag when no new staged write collides
  a_r9_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pend_q && !hit_ps && !hit_cs) |=> !pend_q);
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   per_eff, cnt_inc;
  logic             cnt_en;

  always_comb begin
    per_eff = (per_act == '0) ? ONE : {1'b0, per_act};
    cnt_inc = {1'b0, cnt_q} + ONE;
    wrap    = run & (cnt_inc >= per_eff);
    cnt_en  = run;
    cnt_d   = wrap ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R3: a stopped counter holds its value
  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R4: a wrap returns the count to zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/apwm_outstage.sv
module apwm_outstage #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             [CNT_W-1:0] cnt,
  input  logic             [CNT_W-1:0] cmp,
  input  apwm_pkg::apwm_mode_t         mode_bits,
  output logic                         pwm
);
  logic below;

  always_comb begin
    below = (cnt < cmp);
    pwm   = mode_bits.mode & (below ^ mode_bits.inv);
  end
endmodule

// File: rtl/aux_pwm_shadowed.sv
module aux_pwm_shadowed
  import apwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] per_act, cmp_act, cnt;
  logic              wrap;
  apwm_mode_t        mode_bits;

  apwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wrap      (wrap),
    .per_act   (per_act),
    .cmp_act   (cmp_act),
    .mode_bits (mode_bits),
    .bus_rdata (bus_rdata)
  );

  apwm_counter #(.CNT_W(DATA_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode_bits.run),
    .per_act (per_act),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  apwm_outstage #(.CNT_W(DATA_W)) u_out (
    .cnt       (cnt),
    .cmp       (cmp_act),
    .mode_bits (mode_bits),
    .pwm       (pwm_out)
  );

  // R7: output parked low while PWM mode is off
  a_r7_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_bits.mode |-> !pwm_out);

  // R5: compare of zero with normal polarity never drives high
  a_r5_zero_cmp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits.mode && !mode_bits.inv && cmp_act == '0) |-> !pwm_out);
endmodule

// File: tb/test_aux_pwm_shadowed.sv
`timescale 1ns/1ps
module test_aux_pwm_shadowed;
  localparam logic [5:0] A_PA = 6'h08, A_CA = 6'h0C, A_PS = 6'h10, A_CS = 6'h14, A_CT = 6'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  aux_pwm_shadowed i_aux_pwm_shadowed (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference model
  logic [31:0] m_pa = 0, m_ca = 0, m_ps = 0, m_cs = 0, m_cnt = 0, m_rd = 0;
  logic [15:0] m_ctl = 0;
  bit          m_pend = 0;

  function automatic bit model_out();
    if (!m_ctl[9]) return 1'b0;
    return (m_cnt < m_ca) ^ m_ctl[10];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pa = 0; m_ca = 0; m_ps = 0; m_cs = 0; m_cnt = 0; m_rd = 0; m_ctl = 0; m_pend = 0;
    end else begin
      longint peff, nxt;
      bit wr, rdq, wrapv;
      logic [31:0] rdv;
      peff  = (m_pa == 0) ? 1 : longint'(m_pa);
      nxt   = longint'(m_cnt) + 1;
      wrapv = m_ctl[4] && (nxt >= peff);
      wr    = bus_valid && bus_write;
      rdq   = bus_valid && !bus_write;
      rdv   = 0;
      if (rdq) begin
        if (bus_addr == A_PA) rdv = m_pa;
        else if (bus_addr == A_CA) rdv = m_ca;
        else if (bus_addr == A_PS) rdv = m_ps;
        else if (bus_addr == A_CS) rdv = m_cs;
        else if (bus_addr == A_CT) rdv = {16'h0, m_ctl};
      end
      m_rd = rdv;
      if (wrapv && m_pend) begin
        m_pa = m_ps; m_ca = m_cs; m_pend = 0;
      end
      if (m_ctl[4]) m_cnt = wrapv ? 0 : m_cnt + 1;
      if (wr) begin
        if (bus_addr == A_PA) m_pa = bus_wdata;
        if (bus_addr == A_CA) m_ca = bus_wdata;
        if (bus_addr == A_PS) begin m_ps = bus_wdata; m_pend = 1; end
        if (bus_addr == A_CS) begin m_cs = bus_wdata; m_pend = 1; end
        if (bus_addr == A_CT) m_ctl = bus_wdata[15:0];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwm_out !== model_out()) begin
        errors++;
        $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, pwm_out, model_out(), $time);
      end
      checks++;
      if (bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL %s: bus_rdata=%h expected %h at %0t", tag, bus_rdata, m_rd, $time);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string t);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read %h got %h expected %h", t, a, bus_rdata, exp);
    end
  endtask

  task automatic bit_chk(input logic exp, input string t);
    checks++;
    if (pwm_out !== exp) begin
      errors++;
      $display("FAIL %s: pwm_out=%0b expected %0b", t, pwm_out, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    tag = "R1";
    bit_chk(1'b0, "R1");
    rd_chk(A_PA, 0, "R1"); rd_chk(A_CA, 0, "R1"); rd_chk(A_PS, 0, "R1");
    rd_chk(A_CS, 0, "R1"); rd_chk(A_CT, 0, "R1");

    // R2: map and read-back
    tag = "R2";
    wr(A_PA, 32'h1122_3344); wr(A_CA, 32'h5566_7788);
    rd_chk(A_PA, 32'h1122_3344, "R2"); rd_chk(A_CA, 32'h5566_7788, "R2");
    wr(A_CT, 32'hFFFF_F80F); rd_chk(A_CT, 32'h0000_F80F, "R2");
    wr(A_CT, 0);
    rd_chk(6'h00, 0, "R2"); rd_chk(6'h2C, 0, "R2");

    // R11: sync field reads back
    tag = "R11";
    wr(A_CT, 32'h0000_00C0); rd_chk(A_CT, 32'h0000_00C0, "R11");

    // R10/R4/R5: direct setup then run
    tag = "R10";
    wr(A_CT, 0); wr(A_PA, 5); wr(A_CA, 2);
    rd_chk(A_PA, 5, "R10");
    tag = "R5";
    wr(A_CT, 32'h0210); idle(20);
    tag = "R11";
    wr(A_CT, 32'h02D0); idle(12);

    // R3: stop holds
    tag = "R3";
    wr(A_CT, 32'h0200); idle(10);
    wr(A_CT, 32'h0210); idle(7);

    // R6: inverted
    tag = "R6";
    wr(A_CT, 32'h0610); idle(15);

    // R5 boundaries
    tag = "R5";
    wr(A_CT, 32'h0210);
    wr(A_CA, 0); idle(8); bit_chk(1'b0, "R5");
    wr(A_CA, 7); idle(8); bit_chk(1'b1, "R5");
    wr(A_PA, 1); wr(A_CA, 1); idle(6); bit_chk(1'b1, "R5");
    tag = "R4";
    wr(A_PA, 0); wr(A_CA, 1); idle(6); bit_chk(1'b1, "R4");
    wr(A_PA, 4); wr(A_CA, 3); idle(12);

    // R7: mode off parks low
    tag = "R7";
    wr(A_CT, 32'h0010); idle(8); bit_chk(1'b0, "R7");
    wr(A_CT, 32'h0410); idle(8); bit_chk(1'b0, "R7");

    // R8: staged values commit at the wrap
    tag = "R8";
    wr(A_CT, 32'h0210); wr(A_PA, 8); wr(A_CA, 4); idle(3);
    wr(A_PS, 3); rd_chk(A_PA, 8, "R8");
    wr(A_CS, 1); idle(20);
    rd_chk(A_PA, 3, "R8"); rd_chk(A_CA, 1, "R8");

    // R9: no copy without pending; collisions with wraps
    tag = "R9";
    wr(A_PA, 6); wr(A_CA, 2); idle(20);
    rd_chk(A_PA, 6, "R9"); rd_chk(A_CA, 2, "R9");
    wr(A_PA, 3);
    for (int i = 0; i < 12; i++) wr(A_CS, 32'(i));
    idle(12);
    rd_chk(A_CA, 11, "R9");

    // R10: direct write while running is used next cycle
    tag = "R10";
    wr(A_CA, 0); bit_chk(1'b0, "R10");
    wr(A_CA, 9); bit_chk(1'b1, "R10");
    idle(4);

    finish_run();
  end
endmodule